// File: doc/BRIEF.md
# Vector Horizontal Reduction Unit

This unit folds a K-lane vector of signed bytes into a single scalar and writes that scalar to every 32-bit lane of a wide destination register. It offers three reductions: a signed sum, a signed maximum and a signed minimum. Each byte lane is sign-extended to 32 bits before it enters any of the three trees. The max and min results therefore come out already sign-extended to the full word.

The unit also drives the two register-file write enables for each operation it retires. A reduction always goes to the wide register file. The narrow (byte) register file is never written by a reduction, even when the 2-bit register-class field names the narrow class. For a reduction, that field only states where the operand came from. Opcodes that are not reductions follow the ordinary rule: the wide enable follows the wide class and the narrow enable follows the narrow class.

A two-state controller tracks whether a result is pending. `ST_IDLE` means no result is pending and `ST_EMIT` means a registered result is on the outputs. The controller takes these transitions:
- `IDLE_TO_EMIT` on a valid input while in `ST_IDLE`.
- `EMIT_HOLD` on a back-to-back valid input while in `ST_EMIT`.
- `EMIT_TO_IDLE` when no valid input arrives while in `ST_EMIT`.
- `IDLE_HOLD` when no valid input arrives while in `ST_IDLE`.

Every result and enable appears exactly one clock after its valid input.

Top module: `rdx_unit`

## Requirements
- R1: With opcode 4'h1 (sum), the result is the sum of all K lanes, each sign-extended to 32 bits, computed without saturation.
- R2: With opcode 4'h2 (max), the result is the largest lane when the lanes are read as signed bytes, sign-extended to 32 bits.
- R3: With opcode 4'h3 (min), the result is the smallest lane when the lanes are read as signed bytes, sign-extended to 32 bits.
- R4: The scalar result is written identically into every one of the K 32-bit lanes of `out_wide_vec`; lane i occupies bits [32*i+31:32*i].
- R5: For opcodes 4'h1, 4'h2 and 4'h3, `out_wide_we` is 1 for every value of the register-class field.
- R6: For opcodes 4'h1, 4'h2 and 4'h3, `out_narrow_we` is 0 for every value of the register-class field, including 2'b01 (narrow).
- R7: For any other opcode, `out_wide_we` equals (class == 2'b00) and `out_narrow_we` equals (class == 2'b01), and `out_wide_vec` is all zeros.
- R8: `out_valid`, the enables, the result and the two carried destination addresses appear exactly one cycle after `in_valid`. A cycle without `in_valid` yields `out_valid`=0 and both enables at 0.
- R9: While reset is asserted, `out_valid`, both enables, the addresses and `out_wide_vec` are all zero.
- R10: With K=8 and every lane 8'hFF, the sum result is -8 (32'hFFFF_FFF8). With every lane 8'h80, it is -1024.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation presented this cycle |
| in_op | input | 4 | Opcode: 1 sum, 2 max, 3 min, other values are not reductions |
| in_rcls | input | 2 | Register class: 00 wide, 01 narrow, 10/11 neither |
| in_vec | input | 8*LANES | Source bytes, lane i at bits [8*i+7:8*i] |
| in_wide_addr | input | AW | Wide destination register index |
| in_narrow_addr | input | AW | Narrow destination register index |
| out_valid | output | 1 | Registered result present |
| out_wide_vec | output | 32*LANES | Broadcast result |
| out_wide_we | output | 1 | Wide register-file write enable |
| out_narrow_we | output | 1 | Narrow register-file write enable |
| out_wide_addr | output | AW | Carried wide destination index |
| out_narrow_addr | output | AW | Carried narrow destination index |

## Verification
The bench targets sign handling at the byte extremes: all lanes -1, all lanes -128, all lanes 127, and a single extreme value among zeros. A design that zero-extends its lanes would turn the all-ones sum into 2040 instead of -8, and would report 0x80 as the maximum. Reductions are issued under every register class. A design that lets the class field gate the wide enable would drop the result, and one that lets it drive the narrow enable would corrupt a byte register. Idle gaps and back-to-back issues check that enables never leak into a cycle without a result. Random opcodes, classes and vectors then compare every lane against bench-computed values.

// File: rtl/rdx_pkg.sv
package rdx_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 32;

    localparam logic [3:0] OPC_SUM = 4'h1;
    localparam logic [3:0] OPC_MAX = 4'h2;
    localparam logic [3:0] OPC_MIN = 4'h3;

    typedef enum logic [1:0] {
        RC_WIDE   = 2'b00,
        RC_NARROW = 2'b01,
        RC_RSV2   = 2'b10,
        RC_RSV3   = 2'b11
    } rdx_cls_e;

    typedef enum logic [1:0] {
        RK_NONE = 2'd0,
        RK_SUM  = 2'd1,
        RK_MAX  = 2'd2,
        RK_MIN  = 2'd3
    } rdx_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } rdx_state_e;

    function automatic rdx_kind_e op_to_kind(input logic [3:0] op);
        rdx_kind_e k;
        unique case (op)
            OPC_SUM: k = RK_SUM;
            OPC_MAX: k = RK_MAX;
            OPC_MIN: k = RK_MIN;
            default: k = RK_NONE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/rdx_tree.sv
module rdx_tree
    import rdx_pkg::*;
#(
    parameter int        LEAVES = 8,
    parameter int        W      = 32,
    parameter rdx_kind_e MODE   = RK_SUM
) (
    input  logic [LEAVES*W-1:0] leaves,
    output logic [W-1:0]        root
);

    localparam int NODES = 2 * LEAVES - 1;

    function automatic logic [W-1:0] combine(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] r;
        if (MODE == RK_MAX) begin
            r = ($signed(a) > $signed(b)) ? a : b;
        end else if (MODE == RK_MIN) begin
            r = ($signed(a) < $signed(b)) ? a : b;
        end else begin
            r = a + b;
        end
        return r;
    endfunction

    logic [W-1:0] node [NODES];

    always_comb begin
        for (int i = 0; i < LEAVES; i++) begin
            node[LEAVES - 1 + i] = leaves[i*W +: W];
        end
        for (int i = LEAVES - 2; i >= 0; i--) begin
            node[i] = combine(node[2*i + 1], node[2*i + 2]);
        end
    end

    assign root = node[0];

endmodule

// File: rtl/rdx_we_gen.sv
module rdx_we_gen
    import rdx_pkg::*;
(
    input  rdx_kind_e   kind,
    input  logic [1:0]  rcls,
    output logic        wide_we,
    output logic        narrow_we
);

    always_comb begin
        if (kind != RK_NONE) begin
            wide_we   = 1'b1;
            narrow_we = 1'b0;
        end else begin
            wide_we   = (rcls == RC_WIDE);
            narrow_we = (rcls == RC_NARROW);
        end
    end

endmodule

// File: rtl/rdx_unit.sv
module rdx_unit
    import rdx_pkg::*;
#(
    parameter int LANES = 8,
    parameter int AW    = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [3:0]              in_op,
    input  logic [1:0]              in_rcls,
    input  logic [LANES*BYTE_W-1:0] in_vec,
    input  logic [AW-1:0]           in_wide_addr,
    input  logic [AW-1:0]           in_narrow_addr,
    output logic                    out_valid,
    output logic [LANES*WORD_W-1:0] out_wide_vec,
    output logic                    out_wide_we,
    output logic                    out_narrow_we,
    output logic [AW-1:0]           out_wide_addr,
    output logic [AW-1:0]           out_narrow_addr
);

    localparam int EXT_W = WORD_W - BYTE_W;

    rdx_state_e state_q, state_d;
    rdx_kind_e  kind;
    logic [LANES*WORD_W-1:0] ext_lanes;
    logic [LANES*WORD_W-1:0] bcast;
    logic [WORD_W-1:0] sum_root, max_root, min_root, scalar;
    logic wide_we_d, narrow_we_d;

    assign kind = op_to_kind(in_op);

    for (genvar l = 0; l < LANES; l++) begin : g_ext
        assign ext_lanes[l*WORD_W +: WORD_W] =
            {{EXT_W{in_vec[l*BYTE_W + BYTE_W - 1]}}, in_vec[l*BYTE_W +: BYTE_W]};
    end

    rdx_tree #(.LEAVES(LANES), .W(WORD_W), .MODE(RK_SUM)) u_sum (
        .leaves (ext_lanes),
        .root   (sum_root)
    );

    rdx_tree #(.LEAVES(LANES), .W(WORD_W), .MODE(RK_MAX)) u_max (
        .leaves (ext_lanes),
        .root   (max_root)
    );

    rdx_tree #(.LEAVES(LANES), .W(WORD_W), .MODE(RK_MIN)) u_min (
        .leaves (ext_lanes),
        .root   (min_root)
    );

    rdx_we_gen u_we (
        .kind      (kind),
        .rcls      (in_rcls),
        .wide_we   (wide_we_d),
        .narrow_we (narrow_we_d)
    );

    always_comb begin
        unique case (kind)
            RK_SUM:  scalar = sum_root;
            RK_MAX:  scalar = max_root;
            RK_MIN:  scalar = min_root;
            default: scalar = '0;
        endcase
    end

    for (genvar l = 0; l < LANES; l++) begin : g_bcast
        assign bcast[l*WORD_W +: WORD_W] = scalar;
    end

    // Next-state logic: IDLE_TO_EMIT, EMIT_HOLD, EMIT_TO_IDLE, IDLE_HOLD
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_wide_vec    <= '0;
            out_wide_we     <= 1'b0;
            out_narrow_we   <= 1'b0;
            out_wide_addr   <= '0;
            out_narrow_addr <= '0;
        end else if (state_d == ST_EMIT) begin
            out_wide_vec    <= bcast;
            out_wide_we     <= wide_we_d;
            out_narrow_we   <= narrow_we_d;
            out_wide_addr   <= in_wide_addr;
            out_narrow_addr <= in_narrow_addr;
        end else begin
            out_wide_we     <= 1'b0;
            out_narrow_we   <= 1'b0;
        end
    end

    assign out_valid = (state_q == ST_EMIT);

endmodule

// File: rtl/rdx_unit_chk.sv
module rdx_unit_chk
    import rdx_pkg::*;
#(
    parameter int LANES = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic [3:0]              in_op,
    input logic [1:0]              in_rcls,
    input logic                    out_valid,
    input logic [LANES*WORD_W-1:0] out_wide_vec,
    input logic                    out_wide_we,
    input logic                    out_narrow_we
);

    logic is_red;
    assign is_red = (in_op == OPC_SUM) || (in_op == OPC_MAX) || (in_op == OPC_MIN);

    AST_REDUCE_WIDE_WE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_red) |=> out_wide_we); // R5

    AST_REDUCE_NO_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_red) |=> !out_narrow_we); // R6

    AST_PLAIN_WIDE_WE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_red) |=> (out_wide_we == $past(in_rcls == RC_WIDE))); // R7

    AST_PLAIN_NARROW_WE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_red) |=> (out_narrow_we == $past(in_rcls == RC_NARROW))); // R7

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_wide_we && !out_narrow_we)); // R8

    AST_MAX_IN_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OPC_MAX) |=>
        ($signed(out_wide_vec[WORD_W-1:0]) >= -128 && $signed(out_wide_vec[WORD_W-1:0]) <= 127)); // R2

    AST_MIN_IN_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OPC_MIN) |=>
        ($signed(out_wide_vec[WORD_W-1:0]) >= -128 && $signed(out_wide_vec[WORD_W-1:0]) <= 127)); // R3

    for (genvar l = 1; l < LANES; l++) begin : g_lane_eq
        AST_BCAST_LANE: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (out_wide_vec[l*WORD_W +: WORD_W] == out_wide_vec[WORD_W-1:0])); // R4
    end

endmodule

bind rdx_unit rdx_unit_chk #(.LANES(LANES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_op         (in_op),
    .in_rcls       (in_rcls),
    .out_valid     (out_valid),
    .out_wide_vec  (out_wide_vec),
    .out_wide_we   (out_wide_we),
    .out_narrow_we (out_narrow_we)
);

// File: tb/rdx_unit_bench.sv
module rdx_unit_bench;

    localparam int LANES = 8;
    localparam int AW    = 5;
    localparam int VW    = LANES * 8;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic [3:0]           in_op = '0;
    logic [1:0]           in_rcls = '0;
    logic [VW-1:0]        in_vec = '0;
    logic [AW-1:0]        in_wide_addr = '0;
    logic [AW-1:0]        in_narrow_addr = '0;
    logic                 out_valid;
    logic [LANES*32-1:0]  out_wide_vec;
    logic                 out_wide_we;
    logic                 out_narrow_we;
    logic [AW-1:0]        out_wide_addr;
    logic [AW-1:0]        out_narrow_addr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rdx_unit #(.LANES(LANES), .AW(AW)) u_rdx_unit (
        .clk             (clk),
        .rst_n           (rst_n),
        .in_valid        (in_valid),
        .in_op           (in_op),
        .in_rcls         (in_rcls),
        .in_vec          (in_vec),
        .in_wide_addr    (in_wide_addr),
        .in_narrow_addr  (in_narrow_addr),
        .out_valid       (out_valid),
        .out_wide_vec    (out_wide_vec),
        .out_wide_we     (out_wide_we),
        .out_narrow_we   (out_narrow_we),
        .out_wide_addr   (out_wide_addr),
        .out_narrow_addr (out_narrow_addr)
    );

    function automatic int lane_val(input logic [VW-1:0] v, input int i);
        logic signed [7:0] b;
        b = v[i*8 +: 8];
        return int'(b);
    endfunction

    function automatic logic [31:0] ref_scalar(input logic [3:0] op, input logic [VW-1:0] v);
        int acc;
        if (op == 4'h1) begin
            acc = 0;
            for (int i = 0; i < LANES; i++) acc += lane_val(v, i);
        end else if (op == 4'h2) begin
            acc = -1000;
            for (int i = 0; i < LANES; i++) if (lane_val(v, i) > acc) acc = lane_val(v, i);
        end else if (op == 4'h3) begin
            acc = 1000;
            for (int i = 0; i < LANES; i++) if (lane_val(v, i) < acc) acc = lane_val(v, i);
        end else begin
            acc = 0;
        end
        return 32'(acc);
    endfunction

    function automatic string req_of(input logic [3:0] op);
        if (op == 4'h1) return "R1";
        if (op == 4'h2) return "R2";
        if (op == 4'h3) return "R3";
        return "R7";
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drive one operation at a falling edge, sample one full cycle later.
    task automatic issue(input logic [3:0] op, input logic [1:0] rcls, input logic [VW-1:0] v,
                         input logic [AW-1:0] wa, input logic [AW-1:0] na);
        logic [31:0] exp_s;
        logic red;
        in_valid = 1'b1; in_op = op; in_rcls = rcls; in_vec = v;
        in_wide_addr = wa; in_narrow_addr = na;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        red = (op == 4'h1) || (op == 4'h2) || (op == 4'h3);
        exp_s = ref_scalar(op, v);
        chk("R8", "out_valid", 32'(out_valid), 32'd1);
        chk("R8", "wide_addr", 32'(out_wide_addr), 32'(wa));
        chk("R8", "narrow_addr", 32'(out_narrow_addr), 32'(na));
        for (int l = 0; l < LANES; l++) begin
            chk(l == 0 ? req_of(op) : "R4", "lane", out_wide_vec[l*32 +: 32], exp_s);
        end
        if (red) begin
            chk("R5", "wide_we", 32'(out_wide_we), 32'd1);
            chk("R6", "narrow_we", 32'(out_narrow_we), 32'd0);
        end else begin
            chk("R7", "wide_we", 32'(out_wide_we), 32'(rcls == 2'b00));
            chk("R7", "narrow_we", 32'(out_narrow_we), 32'(rcls == 2'b01));
        end
    endtask

    task automatic idle_check;
        @(posedge clk);
        @(negedge clk);
        chk("R8", "idle out_valid", 32'(out_valid), 32'd0);
        chk("R8", "idle wide_we", 32'(out_wide_we), 32'd0);
        chk("R8", "idle narrow_we", 32'(out_narrow_we), 32'd0);
    endtask

    function automatic logic [VW-1:0] fill(input logic [7:0] b);
        logic [VW-1:0] v;
        for (int i = 0; i < LANES; i++) v[i*8 +: 8] = b;
        return v;
    endfunction

    initial begin
        logic [VW-1:0] v;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R9", "reset out_valid", 32'(out_valid), 32'd0);
        chk("R9", "reset wide_we", 32'(out_wide_we), 32'd0);
        chk("R9", "reset narrow_we", 32'(out_narrow_we), 32'd0);
        chk("R9", "reset wide_addr", 32'(out_wide_addr), 32'd0);
        chk("R9", "reset lane0", out_wide_vec[31:0], 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 directed corners
        issue(4'h1, 2'b01, fill(8'hFF), 5'd3, 5'd7);
        chk("R10", "all -1 sum", out_wide_vec[31:0], 32'hFFFF_FFF8);
        issue(4'h1, 2'b00, fill(8'h80), 5'd1, 5'd2);
        chk("R10", "all -128 sum", out_wide_vec[31:0], 32'hFFFF_FC00);
        issue(4'h1, 2'b10, fill(8'h7F), 5'd4, 5'd5);
        issue(4'h2, 2'b01, fill(8'h80), 5'd6, 5'd6);
        issue(4'h3, 2'b11, fill(8'h7F), 5'd8, 5'd9);
        v = '0; v[15:8] = 8'h80;
        issue(4'h3, 2'b01, v, 5'd10, 5'd11);
        issue(4'h2, 2'b01, v, 5'd12, 5'd13);
        v = fill(8'hF0); v[VW-1 -: 8] = 8'h7F;
        issue(4'h2, 2'b00, v, 5'd14, 5'd15);
        idle_check();
        issue(4'h5, 2'b00, fill(8'h11), 5'd16, 5'd17);
        issue(4'h0, 2'b01, fill(8'h22), 5'd18, 5'd19);
        issue(4'h9, 2'b10, fill(8'h33), 5'd20, 5'd21);
        idle_check();

        for (int n = 0; n < 400; n++) begin
            logic [3:0] op;
            logic [1:0] rc;
            op = 4'($urandom_range(0, 5));
            rc = 2'($urandom_range(0, 3));
            v  = {$urandom, $urandom};
            issue(op, rc, v, 5'($urandom), 5'($urandom));
            if (($urandom % 5) == 0) idle_check();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R8 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule